// File: doc/BRIEF.md
# Read-While-Write Flash Access Controller

This block sits between a CPU's instruction/data read port and a page-programmable flash. It takes page erase and page write commands, each carrying a target page number. It sorts the target into one of two fixed regions using a parameterised split page. Pages below the split form the concurrent region. Pages at or above it form the exclusive region, which also holds the boot code. The region of an operation depends only on the command's target page, never on the address the CPU happens to read.

Programming a concurrent-region page leaves the CPU running. Fetches from the exclusive region are served as usual. Any read of the concurrent region is answered with a fixed filler word and flagged by a one-cycle violation pulse. Programming an exclusive-region page holds the CPU stall output high for the whole operation, and no read is served. A busy flag marks the concurrent region as blocked. It rises when a concurrent-region operation is accepted and stays set after that operation finishes, until software issues an explicit clear while no operation is running.

Each operation lasts a parameterised number of cycles. It ends with a one-cycle done pulse. A command that arrives while an operation is running is refused and reported with a one-cycle error pulse.

Top module: `rww_flash_ctrl`

## Requirements
- R1: After reset, op_active, cpu_stall, rww_busy, op_done, cmd_err, rd_valid, rd_violation and fl_prog_start are all 0.
- R2: A page number below RWW_PAGES (default 48) belongs to the concurrent region, and any page at or above it belongs to the exclusive region. Page 47 behaves as concurrent and page 48 as exclusive. The page of a read address is rd_addr[ADDR_W-1:OFS_W].
- R3: A command is accepted when cmd_valid is 1 and op_active is 0. The next cycle, fl_prog_start pulses for one cycle with the page and the erase bit (cmd_erase: 1 means erase, 0 means write). op_active is then 1 for exactly PROG_CYCLES cycles, and op_done is 1 for the single cycle after that.
- R4: During a concurrent-region operation, cpu_stall stays 0.
- R5: Accepting a concurrent-region command sets rww_busy in the following cycle. rww_busy stays 1 after op_done until it is cleared.
- R6: A read of the concurrent region while rww_busy is 1 does not access the flash (fl_rd_en is 0). One cycle later it returns rd_valid 1, rd_data equal to FILLER_WORD and a one-cycle rd_violation pulse.
- R7: During an exclusive-region operation, cpu_stall is 1 for all PROG_CYCLES cycles and rww_busy does not change. A read request while stalled is not served: fl_rd_en is 0, and the next cycle shows rd_valid 0 and rd_violation 0.
- R8: busy_clr is ignored while op_active is 1. When op_active is 0, busy_clr makes rww_busy 0 in the next cycle.
- R9: A command that arrives while op_active is 1 produces a one-cycle cmd_err pulse in the next cycle. It starts nothing: fl_prog_start stays 0 and the running operation keeps its end cycle.
- R10: A read that is not blocked and not stalled drives fl_rd_en with the address. One cycle later it returns rd_valid 1, rd_violation 0 and the flash word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Erase/write command request |
| cmd_erase | input | 1 | 1 = page erase, 0 = page write |
| cmd_page | input | PAGE_W | Target page number |
| busy_clr | input | 1 | Software clear of the busy flag |
| rd_req | input | 1 | CPU read or fetch request |
| rd_addr | input | ADDR_W | CPU word address |
| rd_data | output | DATA_W | Read result, one cycle after the request |
| rd_valid | output | 1 | rd_data holds a served read |
| rd_violation | output | 1 | Pulse: blocked region was read |
| cpu_stall | output | 1 | Halts the CPU |
| op_active | output | 1 | Program operation in progress |
| op_done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | One-cycle rejected-command pulse |
| rww_busy | output | 1 | Concurrent region blocked for reading |
| fl_rd_en | output | 1 | Flash read enable |
| fl_rd_addr | output | ADDR_W | Flash read address |
| fl_rd_data | input | DATA_W | Flash read word, valid one cycle after fl_rd_en |
| fl_prog_start | output | 1 | One-cycle flash program start |
| fl_prog_erase | output | 1 | Kind of the started operation |
| fl_prog_page | output | PAGE_W | Page of the started operation |

## Verification
A wrong region latch or a wrong busy state shows up on the first read after the command. Within one cycle, a read returns the filler word where flash data was expected, or flash data where the filler was expected, and rd_violation gives the same sign. A wrong timer count shows up as op_done or the fall of cpu_stall arriving on a cycle other than PROG_CYCLES after acceptance, so the bench counts cycles from the accept edge. A busy flag that is cleared wrongly shows up on the next concurrent-region read after the clear.

// File: rtl/rww_pkg.sv
// Shared types for the read-while-write flash controller.
package rww_pkg;
    // Region of a page: concurrent keeps other-region reads alive, exclusive halts the CPU.
    typedef enum logic {
        REGION_CONC = 1'b0,
        REGION_EXCL = 1'b1
    } region_e;
endpackage

// File: rtl/rww_region_decode.sv
// Maps a page number to its region by comparing it with a fixed split page.
// Assumes SPLIT_PAGE fits in PAGE_W+1 bits.
module rww_region_decode
    import rww_pkg::*;
#(
    parameter int PAGE_W     = 6,
    parameter int SPLIT_PAGE = 48
) (
    input  logic [PAGE_W-1:0] page,
    output region_e           region
);
    localparam logic [PAGE_W:0] SPLIT = SPLIT_PAGE[PAGE_W:0];

    // Pages below the split are concurrent, all others exclusive.
    always_comb begin
        region = ({1'b0, page} < SPLIT) ? REGION_CONC : REGION_EXCL;
    end
endmodule

// File: rtl/rww_prog_timer.sv
// Counts the length of one program operation. A start loads the counter; active
// is high for exactly PROG_CYCLES cycles, then done pulses for one cycle.
// Assumes start is only raised while active is low.
module rww_prog_timer #(
    parameter int PROG_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic done
);
    localparam int CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PROG_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on start, count down while active, finish at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            active <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                cnt_q  <= LOAD;
                active <= 1'b1;
            end else if (active) begin
                if (cnt_q == '0) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rww_busy_flag.sv
// Busy flag for the concurrent region. Set when a concurrent-region operation
// is accepted; cleared only by software while no operation runs. Set wins.
module rww_busy_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr_req,
    input  logic op_running,
    output logic busy
);
    // Hold the flag until an idle-time clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (set) begin
            busy <= 1'b1;
        end else if (clr_req && !op_running) begin
            busy <= 1'b0;
        end
    end
endmodule

// File: rtl/rww_read_gate.sv
// Gates CPU reads against the programming state. Stalled requests are dropped,
// concurrent-region reads while busy get the filler word and a violation pulse,
// all others go to the flash. Assumes flash data is valid one cycle after fl_rd_en.
module rww_read_gate
    import rww_pkg::*;
#(
    parameter int              ADDR_W      = 10,
    parameter int              OFS_W       = 4,
    parameter int              DATA_W      = 16,
    parameter int              SPLIT_PAGE  = 48,
    parameter logic [DATA_W-1:0] FILLER_WORD = 16'hBAD0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              stall,
    input  logic              busy,
    input  logic [DATA_W-1:0] fl_rd_data,
    output logic              fl_rd_en,
    output logic [ADDR_W-1:0] fl_rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_violation
);
    localparam int PAGE_W = ADDR_W - OFS_W;

    region_e rd_region;
    logic    served;
    logic    blocked;
    logic    fill_q;

    rww_region_decode #(
        .PAGE_W    (PAGE_W),
        .SPLIT_PAGE(SPLIT_PAGE)
    ) u_rd_decode (
        .page  (rd_addr[ADDR_W-1:OFS_W]),
        .region(rd_region)
    );

    // Classify the current request.
    always_comb begin
        served     = rd_req && !stall;
        blocked    = served && busy && (rd_region == REGION_CONC);
        fl_rd_en   = served && !blocked;
        fl_rd_addr = rd_addr;
    end

    // Register the response qualifiers for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid     <= 1'b0;
            rd_violation <= 1'b0;
            fill_q       <= 1'b0;
        end else begin
            rd_valid     <= served;
            rd_violation <= blocked;
            fill_q       <= blocked;
        end
    end

    // Select the filler for blocked reads, flash data otherwise.
    always_comb begin
        rd_data = fill_q ? FILLER_WORD : fl_rd_data;
    end
endmodule

// File: rtl/rww_flash_ctrl.sv
// Read-while-write flash access controller. Accepts erase/write commands while
// idle, decodes the target region, runs the operation timer, drives the CPU
// stall for exclusive-region operations and keeps the concurrent-region busy flag.
// Assumes the flash model starts an operation on fl_prog_start.
module rww_flash_ctrl
    import rww_pkg::*;
#(
    parameter int                ADDR_W      = 10,
    parameter int                OFS_W       = 4,
    parameter int                DATA_W      = 16,
    parameter int                RWW_PAGES   = 48,
    parameter int                PROG_CYCLES = 20,
    parameter logic [DATA_W-1:0] FILLER_WORD = 16'hBAD0,
    localparam int               PAGE_W      = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_erase,
    input  logic [PAGE_W-1:0] cmd_page,
    input  logic              busy_clr,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_violation,
    output logic              cpu_stall,
    output logic              op_active,
    output logic              op_done,
    output logic              cmd_err,
    output logic              rww_busy,
    output logic              fl_rd_en,
    output logic [ADDR_W-1:0] fl_rd_addr,
    input  logic [DATA_W-1:0] fl_rd_data,
    output logic              fl_prog_start,
    output logic              fl_prog_erase,
    output logic [PAGE_W-1:0] fl_prog_page
);
    region_e cmd_region;
    region_e op_region_q;
    logic    accept;

    rww_region_decode #(
        .PAGE_W    (PAGE_W),
        .SPLIT_PAGE(RWW_PAGES)
    ) u_cmd_decode (
        .page  (cmd_page),
        .region(cmd_region)
    );

    // A command is taken only when no operation runs.
    always_comb begin
        accept = cmd_valid && !op_active;
    end

    rww_prog_timer #(
        .PROG_CYCLES(PROG_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .active(op_active),
        .done  (op_done)
    );

    rww_busy_flag u_busy (
        .clk       (clk),
        .rst_n     (rst_n),
        .set       (accept && (cmd_region == REGION_CONC)),
        .clr_req   (busy_clr),
        .op_running(op_active),
        .busy      (rww_busy)
    );

    // Latch the operation's region and flash command; flag rejected commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_region_q   <= REGION_CONC;
            fl_prog_start <= 1'b0;
            fl_prog_erase <= 1'b0;
            fl_prog_page  <= '0;
            cmd_err       <= 1'b0;
        end else begin
            fl_prog_start <= accept;
            cmd_err       <= cmd_valid && op_active;
            if (accept) begin
                op_region_q   <= cmd_region;
                fl_prog_erase <= cmd_erase;
                fl_prog_page  <= cmd_page;
            end
        end
    end

    // Halt the CPU for the full length of an exclusive-region operation.
    always_comb begin
        cpu_stall = op_active && (op_region_q == REGION_EXCL);
    end

    rww_read_gate #(
        .ADDR_W     (ADDR_W),
        .OFS_W      (OFS_W),
        .DATA_W     (DATA_W),
        .SPLIT_PAGE (RWW_PAGES),
        .FILLER_WORD(FILLER_WORD)
    ) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req      (rd_req),
        .rd_addr     (rd_addr),
        .stall       (cpu_stall),
        .busy        (rww_busy),
        .fl_rd_data  (fl_rd_data),
        .fl_rd_en    (fl_rd_en),
        .fl_rd_addr  (fl_rd_addr),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid),
        .rd_violation(rd_violation)
    );
endmodule

// File: rtl/rww_flash_ctrl_sva.sv
// Port-level properties of the read-while-write controller, bound to the top.
module rww_flash_ctrl_sva #(
    parameter int                ADDR_W      = 10,
    parameter int                OFS_W       = 4,
    parameter int                DATA_W      = 16,
    parameter int                RWW_PAGES   = 48,
    parameter logic [DATA_W-1:0] FILLER_WORD = 16'hBAD0,
    localparam int               PAGE_W      = ADDR_W - OFS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [PAGE_W-1:0] cmd_page,
    input logic              busy_clr,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              rd_violation,
    input logic              cpu_stall,
    input logic              op_active,
    input logic              op_done,
    input logic              cmd_err,
    input logic              rww_busy,
    input logic              fl_rd_en,
    input logic              fl_prog_start
);
    localparam logic [PAGE_W:0] SPLIT = RWW_PAGES[PAGE_W:0];

    logic cmd_low;
    logic rd_low;
    always_comb begin
        cmd_low = ({1'b0, cmd_page} < SPLIT);
        rd_low  = ({1'b0, rd_addr[ADDR_W-1:OFS_W]} < SPLIT);
    end

    p_stall_needs_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> op_active);

    p_stall_drops_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |=> (!rd_valid && !rd_violation));

    p_done_after_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> (!op_active && $past(op_active)));

    p_accept_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !op_active) |=> (fl_prog_start && op_active));

    p_low_sets_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !op_active && cmd_low) |=> (rww_busy && !cpu_stall));

    p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rww_busy && (op_active || !busy_clr)) |=> rww_busy);

    p_busy_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rww_busy && !op_active && busy_clr && !cmd_valid) |=> !rww_busy);

    p_filler_on_violation_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_violation |-> (rd_valid && rd_data == FILLER_WORD));

    p_blocked_no_flash_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rww_busy && !cpu_stall && rd_low) |-> !fl_rd_en);

    p_reject_busy_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op_active) |=> (cmd_err && !fl_prog_start));
endmodule

bind rww_flash_ctrl rww_flash_ctrl_sva #(
    .ADDR_W     (ADDR_W),
    .OFS_W      (OFS_W),
    .DATA_W     (DATA_W),
    .RWW_PAGES  (RWW_PAGES),
    .FILLER_WORD(FILLER_WORD)
) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_page     (cmd_page),
    .busy_clr     (busy_clr),
    .rd_req       (rd_req),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid),
    .rd_violation (rd_violation),
    .cpu_stall    (cpu_stall),
    .op_active    (op_active),
    .op_done      (op_done),
    .cmd_err      (cmd_err),
    .rww_busy     (rww_busy),
    .fl_rd_en     (fl_rd_en),
    .fl_prog_start(fl_prog_start)
);

// File: tb/tb_rww_flash_ctrl.sv
module tb_rww_flash_ctrl;
    localparam int ADDR_W = 10;
    localparam int OFS_W  = 4;
    localparam int DATA_W = 16;
    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam int SPLIT  = 48;
    localparam int P      = 20;
    localparam logic [DATA_W-1:0] FILL = 16'hBAD0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_erase = 1'b0, busy_clr = 1'b0, rd_req = 1'b0;
    logic [PAGE_W-1:0] cmd_page = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data, fl_rd_data;
    logic rd_valid, rd_violation, cpu_stall, op_active, op_done, cmd_err, rww_busy;
    logic fl_rd_en, fl_prog_start, fl_prog_erase;
    logic [ADDR_W-1:0] fl_rd_addr;
    logic [PAGE_W-1:0] fl_prog_page;

    int checks = 0, fails = 0, tick_cnt = 0, acc = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rww_flash_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_erase(cmd_erase),
        .cmd_page(cmd_page), .busy_clr(busy_clr), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_violation(rd_violation),
        .cpu_stall(cpu_stall), .op_active(op_active), .op_done(op_done), .cmd_err(cmd_err),
        .rww_busy(rww_busy), .fl_rd_en(fl_rd_en), .fl_rd_addr(fl_rd_addr),
        .fl_rd_data(fl_rd_data), .fl_prog_start(fl_prog_start),
        .fl_prog_erase(fl_prog_erase), .fl_prog_page(fl_prog_page)
    );

    function automatic logic [DATA_W-1:0] word_of(input logic [ADDR_W-1:0] a);
        return 16'h5A00 ^ {6'b0, a};
    endfunction

    // Flash model: one-cycle read latency.
    always_ff @(posedge clk) begin
        if (fl_rd_en) fl_rd_data <= word_of(fl_rd_addr);
    end

    task automatic tick();
        @(posedge clk);
        #1;
        tick_cnt++;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input string req, input logic [ADDR_W-1:0] a, input bit viol);
        rd_req  = 1'b1;
        rd_addr = a;
        tick();
        rd_req = 1'b0;
        check(req, {31'b0, rd_valid}, 32'd1);
        check(req, {31'b0, rd_violation}, {31'b0, viol});
        check(req, {16'b0, rd_data}, {16'b0, viol ? FILL : word_of(a)});
    endtask

    task automatic issue(input logic [PAGE_W-1:0] pg, input logic er);
        cmd_valid = 1'b1;
        cmd_page  = pg;
        cmd_erase = er;
        tick();
        cmd_valid = 1'b0;
        acc = tick_cnt;
    endtask

    // Advance to the done cycle (PROG_CYCLES after acceptance) and check it.
    task automatic finish_op(input string req);
        while (tick_cnt - acc < P - 1) tick();
        check(req, {31'b0, op_active}, 32'd1);
        tick();
        check(req, {30'b0, op_done, op_active}, 32'd2);
        tick();
        check(req, {31'b0, op_done}, 32'd0);
    endtask

    // Reads made during a concurrent-region operation: {expected violation, address}.
    localparam int NV = 8;
    localparam logic [ADDR_W:0] VEC [NV] = '{
        11'h400, 11'h6FF, 11'h300, 11'h3FF, 11'h550, 11'h305, 11'h6F0, 11'h3A7
    };

    initial begin
        repeat (3) tick();
        // R1: reset state
        check("R1", {24'b0, op_active, cpu_stall, rww_busy, op_done, cmd_err,
                     rd_valid, rd_violation, fl_prog_start}, 32'd0);
        rst_n = 1'b1;
        tick();

        // R10: idle reads
        do_read("R10", 10'h000, 1'b0);
        do_read("R10", 10'h3FF, 1'b0);

        // R3/R4/R5: concurrent-region write of page 5
        issue(6'd5, 1'b0);
        check("R3", {31'b0, fl_prog_start}, 32'd1);
        check("R3", {26'b0, fl_prog_page}, 32'd5);
        check("R3", {31'b0, fl_prog_erase}, 32'd0);
        check("R5", {31'b0, rww_busy}, 32'd1);
        check("R4", {31'b0, cpu_stall}, 32'd0);

        // R8: clear while active is ignored
        busy_clr = 1'b1;
        tick();
        busy_clr = 1'b0;
        check("R8", {31'b0, rww_busy}, 32'd1);

        // R6/R4: table of reads across the split during the operation
        for (int i = 0; i < NV; i++) begin
            do_read(VEC[i][ADDR_W] ? "R6" : "R4", VEC[i][ADDR_W-1:0], VEC[i][ADDR_W]);
        end

        // R9: command while busy is rejected
        issue(6'd60, 1'b1);
        acc = acc - (NV + 2);
        check("R9", {31'b0, cmd_err}, 32'd1);
        check("R9", {31'b0, fl_prog_start}, 32'd0);
        check("R9", {31'b0, cpu_stall}, 32'd0);
        tick();
        check("R9", {31'b0, cmd_err}, 32'd0);
        finish_op("R3");

        // R5/R6: busy persists after completion
        check("R5", {31'b0, rww_busy}, 32'd1);
        do_read("R6", 10'h010, 1'b1);

        // R8: idle clear drops the flag, R10: region readable again
        busy_clr = 1'b1;
        tick();
        busy_clr = 1'b0;
        check("R8", {31'b0, rww_busy}, 32'd0);
        do_read("R10", 10'h010, 1'b0);

        // R2: last concurrent page
        issue(6'd47, 1'b0);
        check("R2", {30'b0, rww_busy, cpu_stall}, 32'd2);
        finish_op("R2");
        busy_clr = 1'b1;
        tick();
        busy_clr = 1'b0;

        // R2/R7: first exclusive page, erase
        issue(6'd48, 1'b1);
        check("R2", {30'b0, rww_busy, cpu_stall}, 32'd1);
        check("R7", {31'b0, fl_prog_erase}, 32'd1);
        rd_req  = 1'b1;
        rd_addr = 10'h3FF;
        #1;
        check("R7", {31'b0, fl_rd_en}, 32'd0);
        tick();
        rd_req = 1'b0;
        check("R7", {30'b0, rd_valid, rd_violation}, 32'd0);
        begin
            int stall_cycles = 2;
            while (tick_cnt - acc < P - 1) begin
                tick();
                if (cpu_stall) stall_cycles++;
            end
            tick();
            check("R7", stall_cycles, P);
            check("R7", {30'b0, cpu_stall, op_done}, 32'd1);
            check("R7", {31'b0, rww_busy}, 32'd0);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule